// File: doc/BRIEF.md
# USB Device Global Interrupt Unit

This unit gathers the device-level events that a USB device core reports and turns them into one interrupt request for a CPU. The events are: end of a bus reset, start of a full-speed frame, start of a high-speed microframe, upstream resume, end of resume and wake-up. Each event arrives as a one-cycle pulse and sets a sticky flag. A seventh flag, suspend, is raised by a detector inside the unit. That detector watches the line state and fires once the bus has sat in the idle J state without a break for three frame periods.

A small register port gives the CPU a flag register and an enable register. Software clears a flag by writing a 0 to its bit, and a 1 leaves that bit unchanged. The interrupt line is driven from a register, and it is high while any flag is set together with its enable bit. The length of a frame period in clock cycles is set by a parameter, so the suspend timing follows the system clock.

Top module: `usb_dev_irq_unit`

## Requirements
- R1: After a synchronous reset the flag register reads 0x00, the enable register reads 0x08 (only the bus-reset-end enable set), and irq is 0.
- R2: Both registers use this bit layout: bit 0 suspend, bit 1 microframe start, bit 2 frame start, bit 3 bus reset end, bit 4 wake-up, bit 5 resume end, bit 6 upstream resume. An input event pulse sampled at a clock edge sets its flag in the value read back after that edge, and the flag stays set until software clears it.
- R3: A write with reg_sel=0 clears every flag bit where the write data is 0 and leaves every flag bit where the write data is 1 unchanged. It never sets a flag.
- R4: When a hardware event and a software clear hit the same flag at the same edge, the flag ends up set.
- R5: A write with reg_sel=1 loads write data bits 6:0 into the enable register, and a read with reg_sel=1 returns them.
- R6: Bit 7 reads 0 in both registers, whatever value was written to it.
- R7: irq is registered. After each edge it equals the OR over all bits of (flag AND enable) as they stood before that edge. A flag whose enable is 0 never raises irq.
- R8: If line_is_j is 1 at N = 3*CYC_PER_MS consecutive edges, the suspend flag reads 1 after the next edge (edge N+1) and still reads 0 after edge N.
- R9: Any edge with line_is_j=0 restarts the idle count. Within one unbroken idle period the suspend flag is set only once, so clearing it while J persists keeps it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_is_j | input | 1 | Bus is in the idle J line state |
| evt_bus_reset_end | input | 1 | Pulse: a bus reset has ended |
| evt_frame_start | input | 1 | Pulse: full-speed frame start token seen |
| evt_uframe_start | input | 1 | Pulse: high-speed microframe start token seen |
| evt_wakeup | input | 1 | Pulse: wake-up event |
| evt_resume_end | input | 1 | Pulse: resume signalling has ended |
| evt_up_resume | input | 1 | Pulse: upstream resume event |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
A hardware event and a software clear can land on the same flag at the same edge. The directed part provokes this by pulsing the frame-start and wake-up inputs while a clear-all write is applied. The flag register must then read with those bits still set and every other bit cleared. The random phase produces the same overlap with random masks and random events, and a bench model in which the event set is applied after the clear mask judges each result.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int NUM_SRC = 7;

    typedef enum logic [2:0] {
        SRC_SUSPEND    = 3'd0,
        SRC_UFRAME     = 3'd1,
        SRC_FRAME      = 3'd2,
        SRC_BUSRST_END = 3'd3,
        SRC_WAKEUP     = 3'd4,
        SRC_RESUME_END = 3'd5,
        SRC_UP_RESUME  = 3'd6
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic {
        SEL_FLAGS   = 1'b0,
        SEL_ENABLES = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        src_vec_t data;
    } reg_wr_t;

    localparam src_vec_t EN_RESET_VAL = src_vec_t'(1) << SRC_BUSRST_END;

    // write-zero-to-clear with hardware set applied last
    function automatic src_vec_t next_flags(src_vec_t cur, logic clr_en,
                                            src_vec_t keep_mask, src_vec_t hw);
        src_vec_t v;
        v = clr_en ? (cur & keep_mask) : cur;
        return v | hw;
    endfunction

    function automatic logic [7:0] widen(src_vec_t v);
        return {1'b0, v};
    endfunction

endpackage

// File: rtl/usb_irq_idle_timer.sv
module usb_irq_idle_timer #(
    parameter int CYC_PER_MS  = 60000,
    parameter int IDLE_FRAMES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_is_j,
    output logic susp_pulse
);
    localparam int LIMIT = CYC_PER_MS * IDLE_FRAMES;
    localparam int CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          fired_q;
    logic          pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!line_is_j) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (!fired_q) begin
                if (cnt_q == CW'(LIMIT - 1)) begin
                    pulse_q <= 1'b1;
                    fired_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign susp_pulse = pulse_q;
endmodule

// File: rtl/usb_irq_flag_reg.sv
module usb_irq_flag_reg
    import usb_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr,
    input  src_vec_t hw_set,
    output src_vec_t flags
);
    logic clr_en;
    assign clr_en = wr.wr && (wr.sel == SEL_FLAGS);

    src_vec_t nxt;
    assign nxt = next_flags(flags, clr_en, wr.data, hw_set);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) flags[i] <= 1'b0;
            else     flags[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/usb_irq_enable_reg.sv
module usb_irq_enable_reg
    import usb_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr,
    output src_vec_t enables
);
    always_ff @(posedge clk) begin
        if (rst)                                  enables <= EN_RESET_VAL;
        else if (wr.wr && wr.sel == SEL_ENABLES)  enables <= wr.data;
    end
endmodule

// File: rtl/usb_dev_irq_unit.sv
module usb_dev_irq_unit
    import usb_irq_pkg::*;
#(
    parameter int CYC_PER_MS  = 60000,
    parameter int IDLE_FRAMES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_is_j,
    input  logic       evt_bus_reset_end,
    input  logic       evt_frame_start,
    input  logic       evt_uframe_start,
    input  logic       evt_wakeup,
    input  logic       evt_resume_end,
    input  logic       evt_up_resume,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    logic     susp_pulse;
    src_vec_t hw_set;
    src_vec_t flags_q;
    src_vec_t en_q;
    reg_wr_t  wr_req;
    logic     wr_flags;
    logic     irq_q;
    logic     unused_wdata_msb;

    assign unused_wdata_msb = reg_wdata[7];

    assign wr_req.wr   = reg_wr;
    assign wr_req.sel  = reg_sel_e'(reg_sel);
    assign wr_req.data = reg_wdata[NUM_SRC-1:0];
    assign wr_flags    = reg_wr && (reg_sel == SEL_FLAGS);

    always_comb begin
        hw_set                 = '0;
        hw_set[SRC_SUSPEND]    = susp_pulse;
        hw_set[SRC_UFRAME]     = evt_uframe_start;
        hw_set[SRC_FRAME]      = evt_frame_start;
        hw_set[SRC_BUSRST_END] = evt_bus_reset_end;
        hw_set[SRC_WAKEUP]     = evt_wakeup;
        hw_set[SRC_RESUME_END] = evt_resume_end;
        hw_set[SRC_UP_RESUME]  = evt_up_resume;
    end

    usb_irq_idle_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .IDLE_FRAMES(IDLE_FRAMES)
    ) u_idle (
        .clk       (clk),
        .rst       (rst),
        .line_is_j (line_is_j),
        .susp_pulse(susp_pulse)
    );

    usb_irq_flag_reg u_flags (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_req),
        .hw_set(hw_set),
        .flags (flags_q)
    );

    usb_irq_enable_reg u_en (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_req),
        .enables(en_q)
    );

    always_comb begin
        unique case (wr_req.sel)
            SEL_FLAGS:   reg_rdata = widen(flags_q);
            SEL_ENABLES: reg_rdata = widen(en_q);
            default:     reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flags_q & en_q);
    end

    assign irq = irq_q;
endmodule

// File: rtl/usb_irq_unit_chk.sv
module usb_irq_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] hw_set,
    input logic       wr_flags,
    input logic [6:0] wmask,
    input logic [6:0] flags,
    input logic [6:0] enables,
    input logic       irq,
    input logic [7:0] rdata,
    input logic       susp_pulse,
    input logic       line_j
);
    // R2 and R4: every hardware set lands, even against a clear
    a_r2_hw_set_lands: assert property (@(posedge clk) disable iff (rst)
        (hw_set != 7'd0) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_flags && hw_set != 7'd0) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
        wr_flags |=> ((flags & ~($past(flags) | $past(hw_set))) == 7'd0)
                     && ((flags & $past(flags) & ~$past(wmask) & ~$past(hw_set)) == 7'd0));

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !wr_flags |=> ((flags & $past(flags)) == $past(flags)));

    a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[7] == 1'b0);

    a_r7_irq_high: assert property (@(posedge clk) disable iff (rst)
        ((flags & enables) != 7'd0) |=> irq);

    a_r7_irq_low: assert property (@(posedge clk) disable iff (rst)
        ((flags & enables) == 7'd0) |=> !irq);

    a_r8_pulse_after_j: assert property (@(posedge clk) disable iff (rst)
        susp_pulse |-> $past(line_j));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        susp_pulse |=> !susp_pulse);
endmodule

bind usb_dev_irq_unit usb_irq_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hw_set    (hw_set),
    .wr_flags  (wr_flags),
    .wmask     (reg_wdata[6:0]),
    .flags     (flags_q),
    .enables   (en_q),
    .irq       (irq),
    .rdata     (reg_rdata),
    .susp_pulse(susp_pulse),
    .line_j    (line_is_j)
);

// File: tb/test_usb_dev_irq_unit.sv
module test_usb_dev_irq_unit;
    localparam int CPM = 10;
    localparam int LIM = 3 * CPM;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_is_j = 1'b0;
    logic [6:1] ev = '0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    logic [6:0] m_flags, m_en;
    logic       m_irq;

    always #4 clk = ~clk;

    usb_dev_irq_unit #(.CYC_PER_MS(CPM), .IDLE_FRAMES(3)) i_usb_dev_irq_unit (
        .clk(clk), .rst(rst), .line_is_j(line_is_j),
        .evt_bus_reset_end(ev[3]), .evt_frame_start(ev[2]),
        .evt_uframe_start(ev[1]), .evt_wakeup(ev[4]),
        .evt_resume_end(ev[5]), .evt_up_resume(ev[6]),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [6:0] model_flags(logic [6:0] f, logic w, logic s,
                                               logic [7:0] d, logic [6:1] e);
        logic [6:0] v;
        v = (w && !s) ? (f & d[6:0]) : f;
        return v | {e, 1'b0};
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic read(input logic s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic check_state(string req);
        logic [7:0] v;
        read(1'b0, v); check(req, v, {1'b0, m_flags});
        read(1'b1, v); check(req, v, {1'b0, m_en});
        check("R7", {7'd0, irq}, {7'd0, m_irq});
    endtask

    // one cycle: drive at negedge, update model at edge, check after
    task automatic step(logic [6:1] e, logic w, logic s, logic [7:0] d, string req);
        ev = e; reg_wr = w; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        m_irq   = |(m_flags & m_en);
        m_flags = model_flags(m_flags, w, s, d, e);
        if (w && s) m_en = d[6:0];
        @(negedge clk);
        ev = '0; reg_wr = 1'b0;
        check_state(req);
    endtask

    task automatic clk_edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_flags = '0; m_en = 7'h08; m_irq = 1'b0;
        check_state("R1");

        // R2 each source sets its own bit
        for (int b = 1; b <= 6; b++) step(6'(1 << (b - 1)), 1'b0, 1'b0, 8'h00, "R2");
        // R3 partial clear keeps 1 bits
        step('0, 1'b1, 1'b0, 8'b0000_0110, "R3");
        // R4 frame and wake-up events against a clear-all
        step(6'b001010, 1'b1, 1'b0, 8'h00, "R4");
        // R5 enable load and R6 reserved bit
        step('0, 1'b1, 1'b1, 8'hFF, "R6");
        step('0, 1'b1, 1'b1, 8'h25, "R5");
        step('0, 1'b1, 1'b0, 8'hFF, "R6");
        step('0, 1'b1, 1'b1, 8'h00, "R7");
        step(6'b111111, 1'b0, 1'b0, 8'h00, "R7");

        for (int i = 0; i < 400; i++) begin
            logic [6:1] e;
            logic w;
            for (int b = 1; b <= 6; b++) e[b] = ($urandom_range(0, 7) == 0);
            w = ($urandom_range(0, 2) == 0);
            step(e, w, 1'($urandom_range(0, 1)), 8'($urandom), "R3");
        end

        // suspend detection
        step('0, 1'b1, 1'b1, 8'h7F, "R5");
        step('0, 1'b1, 1'b0, 8'h00, "R3");
        line_is_j = 1'b1;
        clk_edges(LIM);
        read(1'b0, v); check("R8", {7'd0, v[0]}, 8'd0);
        clk_edges(1);
        read(1'b0, v); check("R8", {7'd0, v[0]}, 8'd1);
        clk_edges(1);
        check("R7", {7'd0, irq}, 8'd1);

        // restart on a single non-J edge
        line_is_j = 1'b0;
        reg_sel = 1'b0; reg_wdata = 8'h00; reg_wr = 1'b1;
        clk_edges(1);
        reg_wr = 1'b0; line_is_j = 1'b1;
        clk_edges(LIM - 1);
        line_is_j = 1'b0;
        clk_edges(1);
        line_is_j = 1'b1;
        clk_edges(LIM);
        read(1'b0, v); check("R9", {7'd0, v[0]}, 8'd0);
        clk_edges(1);
        read(1'b0, v); check("R9", {7'd0, v[0]}, 8'd1);

        // once per idle period
        reg_sel = 1'b0; reg_wdata = 8'h00; reg_wr = 1'b1;
        clk_edges(1);
        reg_wr = 1'b0;
        clk_edges(2 * LIM);
        read(1'b0, v); check("R9", v, 8'h00);
        check("R9", {7'd0, irq}, 8'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule